// File: doc/BRIEF.md
# JTAG Sequence Shifter

This block sits on the programmer side of a debug or programming link. A host controller hands it one command at a time. Each command holds a bit count, a vector of TMS bits, a vector of TDI bits, a pin-format select and a TMS-only flag. The block then produces the matching pin activity for a target's test access port and collects what the target sends back. All vectors are sent least significant bit first. The collected TDO bits are packed in the same order into a result vector.

One sequencing engine serves two pin formats. In the four-wire format it drives separate clock, TMS and TDI pins and samples a TDO pin. In the two-pin format it sends every JTAG bit as a four-clock packet on one bidirectional data pin: a TDI clock, a TMS clock, a turnaround clock and a TDO clock. The data pin is released for the last two clocks. The TMS-only flag turns a command into a state-walk: TDI is forced low and whatever the target returns is discarded. Clock timing comes from a half-period divider, `half_div`. Each half period lasts `half_div + 1` system clocks.

The command side is a valid/ready stream. `cmd_ready` is high only while the engine is idle. A command is taken on the first rising edge where `cmd_valid` and `cmd_ready` are both high. A host that holds `cmd_valid` high while the engine is busy is simply stalled, and none of its fields are looked at until acceptance. The result side has no back-pressure: `done_o` pulses for one cycle and `result_o` then holds its value until the next command is accepted.

Top module: `jtag_seq_shifter`

## Requirements
- R1: After reset and whenever idle, `cmd_ready` is 1. A command is accepted on a rising edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is 0 from the cycle after acceptance until the command ends, and `result_o` keeps its value after `done_o` until the next acceptance.
- R2: A command lasts exactly N half periods of (`half_div`+1) clocks each, with N = 2·len in four-wire format (`cmd_fmt`=0) and N = 8·len in two-pin format (`cmd_fmt`=1). `done_o` is a one-cycle pulse in the cycle `cmd_ready` returns to 1.
- R3: In four-wire format, bit k is presented on `tms_o`/`tdi_o` for a low half and then a high half of `tck_o`. The target samples it at the rising edge between them. Bits go out LSB first, and the data pins never change on a rising edge.
- R4: In four-wire format, `tdo_i` is sampled in the cycle that ends the low half of bit k (the cycle of the rising edge) and stored in `result_o[k]`.
- R5: In two-pin format, each bit uses four clocks, each high then low. Clock 1 drives `dat_o` with the TDI bit, and clock 2 drives it with the TMS bit, both with `dat_oe_o`=1. Clocks 3 and 4 have `dat_oe_o`=0. `dat_o` changes only on rising clock edges, and `tdi_o` stays 0.
- R6: In two-pin format, `dat_i` is sampled at the falling edge of clock 4 of bit k and stored in `result_o[k]`.
- R7: With `cmd_tms_only`=1, the TDI value sent is 0 in both formats whatever `cmd_tdi` holds, and `result_o` is all zeros at `done_o`.
- R8: A `cmd_len` of 0 is executed as 1, and a value above 64 is executed as 64. Result bits at or above the executed length are 0.
- R9: `half_div` and all command fields are captured at acceptance. Changing them while a command runs has no effect on its pins, timing or result.
- R10: An asynchronous low `rst_n` puts the block in its idle state at once, even in the middle of a command: `cmd_ready`=1, `done_o`=0, `tck_o`=0, `tms_o`=0, `tdi_o`=0, `dat_oe_o`=0, `result_o`=0.
- R11: Once a command ends, `tck_o`, `tdi_o` and `dat_oe_o` are 0, and `tms_o` keeps the last value it drove (0 after a two-pin command).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_len | input | 7 | Number of JTAG bits, 1..64 |
| cmd_tms | input | 64 | TMS bits, LSB first |
| cmd_tdi | input | 64 | TDI bits, LSB first |
| cmd_fmt | input | 1 | 0 four-wire pins, 1 two-pin packets |
| cmd_tms_only | input | 1 | State-walk: TDI forced low, returned bits dropped |
| half_div | input | 8 | Half period length minus one, in system clocks |
| tck_o | output | 1 | Test clock (both formats) |
| tms_o | output | 1 | Four-wire TMS |
| tdi_o | output | 1 | Four-wire TDI |
| tdo_i | input | 1 | Four-wire TDO from target |
| dat_o | output | 1 | Two-pin data out |
| dat_oe_o | output | 1 | Two-pin data drive enable |
| dat_i | input | 1 | Two-pin data in |
| done_o | output | 1 | One-cycle end-of-command pulse |
| result_o | output | 64 | Collected target bits, LSB first |

## Verification
The hardest point to reach from the ports is the exact cycle in which a returned bit is taken. In four-wire format it is taken at the end of a low half. In two-pin format it is taken one packet clock after the target starts driving. A design that samples one half period early or late still makes clean-looking pin waveforms.

The bench therefore models the target with two processes that react to the block's own clock edges. One changes TDO on every falling edge. The other changes the two-pin data input only at the falling edge that ends the turnaround clock. Different bit patterns for the target and for the sent vectors expose any shift in the sampling point.

A further run rewrites every command field and the divider right after acceptance. This shows that the running command uses only the values it captured.

// File: rtl/jsq_pkg.sv
package jsq_pkg;

  // pin format of a command
  typedef enum logic {
    FMT_WIRE4 = 1'b0,
    FMT_PKT2  = 1'b1
  } fmt_e;

  // registered pin state
  typedef struct packed {
    logic tck;
    logic tms;
    logic tdi;
    logic dat;
    logic dat_oe;
  } pins_t;

  // clocks per packet in two-pin format, and half periods per packet clock
  localparam int unsigned PKT_CLOCKS  = 4;
  localparam int unsigned HALVES_CLK  = 2;

endpackage

// File: rtl/jsq_halfclk.sv
// Half-period timer: one tick per (limit+1) system clocks while running.
module jsq_halfclk #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || tick) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/jsq_halfdec.sv
// Splits a half-period index into bit index, packet clock and half.
module jsq_halfdec
  import jsq_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  fmt_e               fmt,
  input  logic [IDX_W+2:0]   half,
  output logic [IDX_W-1:0]   bit_idx,
  output logic [1:0]         pclk,
  output logic               second
);

  always_comb begin
    second = half[0];
    if (fmt == FMT_PKT2) begin
      bit_idx = half[IDX_W+2:3];
      pclk    = half[2:1];
    end else begin
      bit_idx = half[IDX_W:1];
      pclk    = 2'd0;
    end
  end

endmodule

// File: rtl/jsq_pindrv.sv
// Pin values for one half period.
module jsq_pindrv
  import jsq_pkg::*;
(
  input  fmt_e       fmt,
  input  logic [1:0] pclk,
  input  logic       second,
  input  logic       tms_bit,
  input  logic       tdi_bit,
  input  logic       tms_only,
  output pins_t      pins
);

  logic tdi_eff;
  assign tdi_eff = tdi_bit & ~tms_only;

  always_comb begin
    pins = '0;
    if (fmt == FMT_WIRE4) begin
      // low half first, rising edge in the middle of the bit
      pins.tck = second;
      pins.tms = tms_bit;
      pins.tdi = tdi_eff;
    end else begin
      // high half first, target samples on the falling edge
      pins.tck = ~second;
      unique case (pclk)
        2'd0: begin
          pins.dat_oe = 1'b1;
          pins.dat    = tdi_eff;
        end
        2'd1: begin
          pins.dat_oe = 1'b1;
          pins.dat    = tms_bit;
        end
        default: begin
          pins.dat_oe = 1'b0;
          pins.dat    = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/jtag_seq_shifter.sv
module jtag_seq_shifter
  import jsq_pkg::*;
#(
  parameter int unsigned MAX_BITS = 64,
  parameter int unsigned DIV_W    = 8,
  localparam int unsigned IDX_W   = $clog2(MAX_BITS),
  localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1),
  localparam int unsigned HALF_W  = IDX_W + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic [MAX_BITS-1:0] cmd_tms,
  input  logic [MAX_BITS-1:0] cmd_tdi,
  input  logic                cmd_fmt,
  input  logic                cmd_tms_only,
  input  logic [DIV_W-1:0]    half_div,
  output logic                tck_o,
  output logic                tms_o,
  output logic                tdi_o,
  input  logic                tdo_i,
  output logic                dat_o,
  output logic                dat_oe_o,
  input  logic                dat_i,
  output logic                done_o,
  output logic [MAX_BITS-1:0] result_o
);

  // captured command
  logic                busy_q;
  fmt_e                fmt_q;
  logic                only_q;
  logic [MAX_BITS-1:0] tms_v_q;
  logic [MAX_BITS-1:0] tdi_v_q;
  logic [DIV_W-1:0]    div_q;
  logic [HALF_W-1:0]   half_q;
  logic [HALF_W-1:0]   last_q;
  logic [MAX_BITS-1:0] cap_q;
  logic                done_q;
  pins_t               pins_q;

  logic accept;
  logic tick;

  assign cmd_ready = ~busy_q;
  assign accept    = cmd_valid & ~busy_q;

  // executed length and final half index
  logic [LEN_W-1:0]  len_eff;
  logic [IDX_W-1:0]  last_bit;
  logic [HALF_W-1:0] last_half;

  always_comb begin
    if (cmd_len == '0) begin
      len_eff = LEN_W'(1);
    end else if (cmd_len > LEN_W'(MAX_BITS)) begin
      len_eff = LEN_W'(MAX_BITS);
    end else begin
      len_eff = cmd_len;
    end
    last_bit = IDX_W'(len_eff - LEN_W'(1));
    if (fmt_e'(cmd_fmt) == FMT_PKT2) begin
      last_half = {last_bit, 3'b111};
    end else begin
      last_half = {2'b00, last_bit, 1'b1};
    end
  end

  // half-period timer
  jsq_halfclk #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy_q),
    .limit   (div_q),
    .tick    (tick)
  );

  // next half: pins to present
  fmt_e                nxt_fmt;
  logic [HALF_W-1:0]   nxt_half;
  logic [MAX_BITS-1:0] nxt_tms_v;
  logic [MAX_BITS-1:0] nxt_tdi_v;
  logic                nxt_only;
  logic [IDX_W-1:0]    nxt_bit;
  logic [1:0]          nxt_pclk;
  logic                nxt_second;
  pins_t               nxt_pins;

  assign nxt_fmt   = accept ? fmt_e'(cmd_fmt) : fmt_q;
  assign nxt_half  = accept ? '0 : half_q + HALF_W'(1);
  assign nxt_tms_v = accept ? cmd_tms : tms_v_q;
  assign nxt_tdi_v = accept ? cmd_tdi : tdi_v_q;
  assign nxt_only  = accept ? cmd_tms_only : only_q;

  jsq_halfdec #(.IDX_W(IDX_W)) u_dec_nxt (
    .fmt     (nxt_fmt),
    .half    (nxt_half),
    .bit_idx (nxt_bit),
    .pclk    (nxt_pclk),
    .second  (nxt_second)
  );

  jsq_pindrv u_pins (
    .fmt      (nxt_fmt),
    .pclk     (nxt_pclk),
    .second   (nxt_second),
    .tms_bit  (nxt_tms_v[nxt_bit]),
    .tdi_bit  (nxt_tdi_v[nxt_bit]),
    .tms_only (nxt_only),
    .pins     (nxt_pins)
  );

  // current half: where returned bits are taken
  logic [IDX_W-1:0] cur_bit;
  logic [1:0]       cur_pclk;
  logic             cur_second;
  logic             cur_take;
  logic             sample_in;

  jsq_halfdec #(.IDX_W(IDX_W)) u_dec_cur (
    .fmt     (fmt_q),
    .half    (half_q),
    .bit_idx (cur_bit),
    .pclk    (cur_pclk),
    .second  (cur_second)
  );

  assign cur_take  = ~cur_second & ((fmt_q == FMT_WIRE4) | (cur_pclk == 2'd3));
  assign sample_in = (fmt_q == FMT_WIRE4) ? tdo_i : dat_i;

  pins_t idle_pins;
  always_comb begin
    idle_pins     = '0;
    idle_pins.tms = pins_q.tms;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fmt_q   <= FMT_WIRE4;
      only_q  <= 1'b0;
      tms_v_q <= '0;
      tdi_v_q <= '0;
      div_q   <= '0;
      half_q  <= '0;
      last_q  <= '0;
      cap_q   <= '0;
      done_q  <= 1'b0;
      pins_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        fmt_q   <= fmt_e'(cmd_fmt);
        only_q  <= cmd_tms_only;
        tms_v_q <= cmd_tms;
        tdi_v_q <= cmd_tdi;
        div_q   <= half_div;
        half_q  <= '0;
        last_q  <= last_half;
        cap_q   <= '0;
        pins_q  <= nxt_pins;
      end else if (busy_q && tick) begin
        if (cur_take && !only_q) begin
          cap_q[cur_bit] <= sample_in;
        end
        if (half_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pins_q <= idle_pins;
        end else begin
          half_q <= nxt_half;
          pins_q <= nxt_pins;
        end
      end
    end
  end

  assign tck_o    = pins_q.tck;
  assign tms_o    = pins_q.tms;
  assign tdi_o    = pins_q.tdi;
  assign dat_o    = pins_q.dat;
  assign dat_oe_o = pins_q.dat_oe;
  assign done_o   = done_q;
  assign result_o = cap_q;

endmodule

// File: rtl/jsq_chk.sv
module jsq_chk #(
  parameter int unsigned MAX_BITS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic                done_o,
  input logic                tck_o,
  input logic                tms_o,
  input logic                tdi_o,
  input logic                dat_o,
  input logic                dat_oe_o,
  input logic [MAX_BITS-1:0] result_o,
  input logic                busy,
  input logic                fmt,
  input logic                only
);

  // R1: acceptance takes ready down on the next cycle
  p_ready_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R2: done is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2: ready is back when done is shown
  p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cmd_ready);

  // R3: four-wire data never moves on a rising clock edge
  p_w4_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fmt && $rose(tck_o) |-> $stable(tms_o) && $stable(tdi_o));

  // R5: two-pin data moves only with a rising clock
  p_pkt_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fmt && !$stable(dat_o) |-> $rose(tck_o));

  // R5: four-wire TDI pin quiet in two-pin format
  p_pkt_tdi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fmt |-> !tdi_o);

  // R7: state-walk keeps TDI low
  p_tms_only_tdi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && only && !fmt |-> !tdi_o);

  // R7: state-walk returns nothing
  p_tms_only_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && only |-> result_o == '0);

  // R11: while idle the clock and the data driver are off
  p_idle_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tck_o && !dat_oe_o);

endmodule

bind jtag_seq_shifter jsq_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .done_o    (done_o),
  .tck_o     (tck_o),
  .tms_o     (tms_o),
  .tdi_o     (tdi_o),
  .dat_o     (dat_o),
  .dat_oe_o  (dat_oe_o),
  .result_o  (result_o),
  .busy      (busy_q),
  .fmt       (fmt_q),
  .only      (only_q)
);

// File: tb/sim_jtag_seq_shifter.sv
module sim_jtag_seq_shifter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [6:0]  cmd_len = '0;
  logic [63:0] cmd_tms = '0;
  logic [63:0] cmd_tdi = '0;
  logic        cmd_fmt = 1'b0;
  logic        cmd_tms_only = 1'b0;
  logic [7:0]  half_div = '0;
  logic        tck_o, tms_o, tdi_o, dat_o, dat_oe_o, done_o;
  logic        tdo_i = 1'b0;
  logic        dat_i = 1'b0;
  logic [63:0] result_o;

  always #10 clk = ~clk;  // 50 MHz

  jtag_seq_shifter u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_len(cmd_len), .cmd_tms(cmd_tms), .cmd_tdi(cmd_tdi), .cmd_fmt(cmd_fmt),
    .cmd_tms_only(cmd_tms_only), .half_div(half_div), .tck_o(tck_o), .tms_o(tms_o),
    .tdi_o(tdi_o), .tdo_i(tdo_i), .dat_o(dat_o), .dat_oe_o(dat_oe_o), .dat_i(dat_i),
    .done_o(done_o), .result_o(result_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // target model and pin monitor
  logic        cur_fmt = 1'b0;
  logic [63:0] cur_tgt = '0;
  logic [63:0] obs_tms = '0;
  logic [63:0] obs_tdi = '0;
  int          rise_n = 0;
  int          fall_n = 0;
  int          tgt_i = 0;
  int          oe_bad = 0;

  always @(posedge tck_o) begin
    if (!cur_fmt) begin
      if (rise_n < 64) begin
        obs_tms[rise_n] = tms_o;
        obs_tdi[rise_n] = tdi_o;
      end
      rise_n++;
    end
  end

  always @(negedge tck_o) begin
    if (!cur_fmt) begin
      tgt_i++;
      if (tgt_i < 64) tdo_i = cur_tgt[tgt_i];
    end else begin
      if (fall_n / 4 < 64) begin
        case (fall_n % 4)
          0: begin obs_tdi[fall_n/4] = dat_o; if (!dat_oe_o) oe_bad++; end
          1: begin obs_tms[fall_n/4] = dat_o; if (!dat_oe_o) oe_bad++; end
          2: begin if (dat_oe_o) oe_bad++; dat_i = cur_tgt[fall_n/4]; end
          default: begin if (dat_oe_o) oe_bad++; end
        endcase
      end
      fall_n++;
    end
  end

  task automatic run_cmd(input logic fmt, input logic only, input logic [6:0] len,
                         input logic [7:0] div, input logic [63:0] tms,
                         input logic [63:0] tdi, input logic [63:0] tgt, input bit perturb);
    int eff;
    int cyc;
    int exp_cyc;
    logic [63:0] mask;
    logic [63:0] res_hold;
    eff = (len == 0) ? 1 : ((len > 64) ? 64 : int'(len));
    mask = (eff == 64) ? '1 : ((64'd1 << eff) - 64'd1);
    @(negedge clk);
    cur_fmt = fmt; cur_tgt = tgt; rise_n = 0; fall_n = 0; tgt_i = 0; oe_bad = 0;
    obs_tms = '0; obs_tdi = '0;
    tdo_i = tgt[0]; dat_i = 1'b0;
    cmd_valid = 1'b1; cmd_len = len; cmd_tms = tms; cmd_tdi = tdi;
    cmd_fmt = fmt; cmd_tms_only = only; half_div = div;
    chk(cmd_ready == 1'b1, "R1 ready idle", 64'(cmd_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    chk(cmd_ready == 1'b0, "R1 ready low after accept", 64'(cmd_ready), 64'd0);
    if (perturb) begin  // R9: fields rewritten while running
      cmd_tms = ~tms; cmd_tdi = ~tdi; cmd_len = 7'd1; cmd_fmt = ~fmt;
      cmd_tms_only = ~only; half_div = div + 8'd3;
    end
    while (!done_o && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    exp_cyc = eff * (fmt ? 8 : 2) * (int'(div) + 1) + 1;
    chk(cyc == exp_cyc, perturb ? "R9 duration" : "R2 duration", 64'(cyc), 64'(exp_cyc));
    chk(cmd_ready == 1'b1, "R2 ready with done", 64'(cmd_ready), 64'd1);
    if (only)
      chk(result_o == '0, "R7 result zero", result_o, 64'd0);
    else
      chk(result_o == (tgt & mask), fmt ? "R6 result" : "R4 result", result_o, tgt & mask);
    chk((obs_tms & mask) == (tms & mask), fmt ? "R5 tms bits" : "R3 tms bits",
        obs_tms & mask, tms & mask);
    chk((obs_tdi & mask) == (only ? 64'd0 : (tdi & mask)), only ? "R7 tdi low" : "R3 R5 tdi bits",
        obs_tdi & mask, only ? 64'd0 : (tdi & mask));
    if (fmt) begin
      chk(oe_bad == 0, "R5 drive enable", 64'(oe_bad), 64'd0);
      chk(fall_n == 4 * eff, "R5 clock count", 64'(fall_n), 64'(4 * eff));
    end else begin
      chk(rise_n == eff, "R3 clock count", 64'(rise_n), 64'(eff));
    end
    res_hold = result_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R2 done single", 64'(done_o), 64'd0);
    chk(result_o == res_hold, "R1 result held", result_o, res_hold);
    chk({tck_o, tdi_o, dat_oe_o} == 3'b000, "R11 idle pins", 64'({tck_o, tdi_o, dat_oe_o}), 64'd0);
    chk(tms_o == (fmt ? 1'b0 : tms[eff-1]), "R11 tms hold", 64'(tms_o), 64'(fmt ? 1'b0 : tms[eff-1]));
  endtask

  typedef struct packed {
    logic        fmt;
    logic        only;
    logic [6:0]  len;
    logic [7:0]  div;
    logic [63:0] tms;
    logic [63:0] tdi;
    logic [63:0] tgt;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 7'd8,  8'd0, 64'h00000000000000A5, 64'h000000000000003C, 64'h0000000000000096},
    '{1'b0, 1'b1, 7'd6,  8'd1, 64'h000000000000001F, 64'h00000000000000FF, 64'h00000000000000FF},
    '{1'b1, 1'b0, 7'd5,  8'd0, 64'h0000000000000013, 64'h000000000000000A, 64'h0000000000000015},
    '{1'b1, 1'b1, 7'd3,  8'd2, 64'h0000000000000005, 64'h0000000000000007, 64'h0000000000000007},
    '{1'b0, 1'b0, 7'd64, 8'd0, 64'hF0E1D2C3B4A59687, 64'h0123456789ABCDEF, 64'hDEADBEEFCAFEF00D},
    '{1'b1, 1'b0, 7'd64, 8'd0, 64'h8000000000000001, 64'hAAAA5555AAAA5555, 64'h00FF00FF00FF00FF},
    '{1'b0, 1'b0, 7'd1,  8'd3, 64'h0000000000000001, 64'h0000000000000001, 64'h0000000000000001},
    '{1'b1, 1'b0, 7'd5,  8'd1, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF}
  };

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog act=%h exp=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && done_o == 1'b0, "R10 reset handshake", 64'({cmd_ready, done_o}), 64'd2);
    chk({tck_o, tms_o, tdi_o, dat_oe_o} == 4'b0, "R10 reset pins",
        64'({tck_o, tms_o, tdi_o, dat_oe_o}), 64'd0);
    chk(result_o == '0, "R10 reset result", result_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      run_cmd(VECS[i].fmt, VECS[i].only, VECS[i].len, VECS[i].div,
              VECS[i].tms, VECS[i].tdi, VECS[i].tgt, 1'b0);
    end

    // R8: zero length runs one bit, oversize runs 64
    run_cmd(1'b0, 1'b0, 7'd0,   8'd1, 64'h3, 64'h3, 64'hFFFF, 1'b0);
    run_cmd(1'b1, 1'b0, 7'd100, 8'd0, 64'h0F0F0F0F0F0F0F0F, 64'h1234, 64'h5A5A5A5A5A5A5A5A, 1'b0);

    // R9: fields and divider rewritten after acceptance
    run_cmd(1'b0, 1'b0, 7'd12, 8'd1, 64'h0A53, 64'h0C3C, 64'h0E71, 1'b1);
    run_cmd(1'b1, 1'b1, 7'd4,  8'd0, 64'h9,    64'hF,    64'hF,    1'b1);

    // R10: reset in the middle of a command
    @(negedge clk);
    cur_fmt = 1'b0;
    cmd_valid = 1'b1; cmd_len = 7'd10; cmd_fmt = 1'b0; cmd_tms_only = 1'b0;
    cmd_tms = 64'h3FF; cmd_tdi = 64'h155; half_div = 8'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(cmd_ready == 1'b1 && done_o == 1'b0, "R10 mid reset handshake", 64'({cmd_ready, done_o}), 64'd2);
    chk({tck_o, tms_o, tdi_o, dat_oe_o} == 4'b0, "R10 mid reset pins",
        64'({tck_o, tms_o, tdi_o, dat_oe_o}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmd(1'b1, 1'b0, 7'd2, 8'd0, 64'h2, 64'h1, 64'h3, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule